// File: doc/BRIEF.md
# Fuse Array Byte-Range Read Sequencer

This block reads a byte range out of a one-time-programmable fuse array of 32 words of 32 bits. A host places a byte offset and a byte length on its request inputs and pulses `start`. The sequencer first wakes the fuse macro with a load configuration and waits one settle interval. It then pulses the macro's strobe once for each word that holds requested bytes, lowest address first, and captures the data word while strobe is high. After a hold interval it moves to the next word. When the last word is done it parks the macro in standby and pulses `done`.

Captured words are broken into bytes, least significant byte first. Only the requested bytes leave the block, on a valid/ready byte stream. A byte is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. The sequencer does not move on to the next strobe until the current word's bytes have drained, so a slow consumer stretches the request and no data is lost. The settle, strobe and hold intervals are each `TICKS_PER_US` clock cycles, so one parameter adapts the pin timing to the clock frequency.

Top module: `fuse_rd_seq`

## Requirements
- R1: Out of reset and while idle, `fuse_ctl` is the standby pattern 0x021 (power-down bit 5 and chip-select-bar bit 0 high, all others low), `busy` is 0, and `out_valid` and `done` are 0.
- R2: After an accepted non-empty request, `fuse_ctl` is the load pattern 0x28C (load bit 2, program-enable-bar bit 3, read-sense bit 7, strobe-timing-select bit 9) for exactly `TICKS_PER_US` cycles before the first strobe.
- R3: Each strobe (bit 1 of `fuse_ctl`, raised on top of the load pattern) stays high for exactly `TICKS_PER_US` cycles with a stable `fuse_addr`. It is followed by at least `TICKS_PER_US` low cycles before the next strobe or standby.
- R4: The words strobed run in ascending order from offset/4 up to ceil((offset+length)/4)-1, with the end limited to word 31. Each word is strobed exactly once.
- R5: The stream carries exactly the requested bytes in ascending byte order. Byte k of a word is bits 8k+7..8k of the captured word, and bytes below the offset inside the first word are dropped.
- R6: `out_last` is high on the final byte of a request and on no other byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged in the next cycle.
- R8: A request with length 0 or with offset 128 or above strobes no word and sends no byte. Its `done` pulse appears in the cycle right after the accepting clock edge.
- R9: `overflow` is high only in the `done` cycle, and only when the length is nonzero and offset+length exceeds 128. Bytes past index 127 are not sent.
- R10: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` pulse while busy launches nothing.
- R11: `done` is a single-cycle pulse, one per accepted request, and `fuse_ctl` is the standby pattern in the `done` cycle and afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while idle |
| req_offset | input | OFF_W | First byte index of the request |
| req_length | input | LEN_W | Number of bytes requested |
| fuse_ctl | output | 10 | Fuse macro control pins (bit positions in R1 to R3) |
| fuse_addr | output | ADDR_W | Word address for the fuse macro |
| fuse_dout | input | 8*WORD_BYTES | Data word returned by the fuse macro |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready from the consumer |
| out_data | output | 8 | Byte stream data |
| out_last | output | 1 | Marks the final byte of a request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Requested range ran past the array end; valid with `done` |

## Verification
The load pattern starts in the cycle after the accepting edge and lasts `TICKS_PER_US` cycles. Each strobe is high for the same count, and for an empty request `done` is due in the very first cycle after the accepting edge. The bench samples every output on the falling clock edge, counts run lengths of the load pattern, strobe-high and strobe-low stretches against these exact figures, and checks `done` for empty requests at the first falling edge after `start`. Byte timing depends on a pseudo-random `out_ready`, so the bench checks the received byte sequence, its `last` marker and the `overflow` flag seen with `done` once the request has ended, rather than at fixed cycles.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int CTL_W = 10;

  // control pin positions on fuse_ctl
  localparam int BIT_CSB    = 0;
  localparam int BIT_STROBE = 1;
  localparam int BIT_LOAD   = 2;
  localparam int BIT_PGENB  = 3;
  localparam int BIT_PD     = 5;
  localparam int BIT_RSB    = 7;
  localparam int BIT_SFTSEL = 9;

  localparam logic [CTL_W-1:0] CTL_STANDBY =
    CTL_W'((1 << BIT_PD) | (1 << BIT_CSB));
  localparam logic [CTL_W-1:0] CTL_LOADCFG =
    CTL_W'((1 << BIT_LOAD) | (1 << BIT_PGENB) | (1 << BIT_RSB) | (1 << BIT_SFTSEL));
  localparam logic [CTL_W-1:0] CTL_STROBE_ON =
    CTL_W'(1 << BIT_STROBE);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_STROBE,
    ST_DRAIN,
    ST_HOLD,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/fuse_range_calc.sv
module fuse_range_calc #(
  parameter int NUM_WORDS  = 32,
  parameter int WORD_BYTES = 4,
  parameter int OFF_W      = 8,
  parameter int LEN_W      = 8,
  localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int POS_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [LEN_W-1:0]  length,
  output logic [WORD_W-1:0] first_word,
  output logic [POS_W-1:0]  first_pos,
  output logic [WORD_W-1:0] last_word,
  output logic [POS_W-1:0]  last_pos,
  output logic              empty,
  output logic              overflow
);
  localparam int TOTAL = NUM_WORDS * WORD_BYTES;
  localparam int SUM_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] TOTAL_S = SUM_W'(TOTAL);

  logic [SUM_W-1:0] off_ext, end_raw, end_cap, end_m1;

  always_comb begin
    off_ext    = SUM_W'(offset);
    end_raw    = off_ext + SUM_W'(length);
    end_cap    = (end_raw > TOTAL_S) ? TOTAL_S : end_raw;
    end_m1     = end_cap - SUM_W'(1);
    empty      = (length == '0) || (off_ext >= TOTAL_S);
    overflow   = (length != '0) && (end_raw > TOTAL_S);
    first_word = WORD_W'(off_ext >> POS_W);
    first_pos  = POS_W'(off_ext);
    last_word  = WORD_W'(end_m1 >> POS_W);
    last_pos   = POS_W'(end_m1);
  end
endmodule

// File: rtl/fuse_tick_timer.sv
module fuse_tick_timer #(
  parameter int TICKS = 125,
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  assign expired = run && (cnt_q == CNT_W'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || expired)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/fuse_byte_emitter.sv
module fuse_byte_emitter #(
  parameter int WORD_BYTES = 4,
  localparam int POS_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int DATA_W = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_word,
  input  logic [POS_W-1:0]  ld_first,
  input  logic [POS_W-1:0]  ld_end,
  input  logic              ld_final,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              active
);
  logic [DATA_W-1:0] word_q;
  logic [POS_W-1:0]  pos_q, end_q;
  logic              final_q, active_q;
  logic [7:0]        lane [WORD_BYTES];

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lane[g] = word_q[8*g +: 8];
  end

  assign out_valid = active_q;
  assign out_data  = lane[pos_q];
  assign out_last  = active_q && final_q && (pos_q == end_q);
  assign active    = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      pos_q    <= '0;
      end_q    <= '0;
      final_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (ld) begin
      word_q   <= ld_word;
      pos_q    <= ld_first;
      end_q    <= ld_end;
      final_q  <= ld_final;
      active_q <= 1'b1;
    end else if (active_q && out_ready) begin
      if (pos_q == end_q) active_q <= 1'b0;
      else                pos_q    <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int NUM_WORDS    = 32,
  parameter int WORD_BYTES   = 4,
  parameter int ADDR_W       = 10,
  parameter int OFF_W        = 8,
  parameter int LEN_W        = 8,
  parameter int TICKS_PER_US = 125,
  localparam int DATA_W = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [LEN_W-1:0]  req_length,
  output logic [9:0]        fuse_ctl,
  output logic [ADDR_W-1:0] fuse_addr,
  input  logic [DATA_W-1:0] fuse_dout,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              busy,
  output logic              done,
  output logic              overflow
);
  localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int POS_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  seq_state_e        state_q;
  logic [WORD_W-1:0] cur_word_q, first_word_q, last_word_q;
  logic [POS_W-1:0]  first_pos_q, last_pos_q;
  logic              ovf_q;

  logic [WORD_W-1:0] calc_first_word, calc_last_word;
  logic [POS_W-1:0]  calc_first_pos, calc_last_pos;
  logic              calc_empty, calc_ovf;
  logic              tick, timer_run, em_load, em_active;

  fuse_range_calc #(
    .NUM_WORDS(NUM_WORDS), .WORD_BYTES(WORD_BYTES),
    .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_range (
    .offset(req_offset), .length(req_length),
    .first_word(calc_first_word), .first_pos(calc_first_pos),
    .last_word(calc_last_word), .last_pos(calc_last_pos),
    .empty(calc_empty), .overflow(calc_ovf)
  );

  assign timer_run = (state_q == ST_WAKE) || (state_q == ST_STROBE) || (state_q == ST_HOLD);

  fuse_tick_timer #(.TICKS(TICKS_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .expired(tick)
  );

  assign em_load = (state_q == ST_STROBE) && tick;

  fuse_byte_emitter #(.WORD_BYTES(WORD_BYTES)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .ld(em_load), .ld_word(fuse_dout),
    .ld_first((cur_word_q == first_word_q) ? first_pos_q : '0),
    .ld_end((cur_word_q == last_word_q) ? last_pos_q : POS_W'(WORD_BYTES - 1)),
    .ld_final(cur_word_q == last_word_q),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .active(em_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_word_q   <= '0;
      first_word_q <= '0;
      last_word_q  <= '0;
      first_pos_q  <= '0;
      last_pos_q   <= '0;
      ovf_q        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          first_word_q <= calc_first_word;
          first_pos_q  <= calc_first_pos;
          last_word_q  <= calc_last_word;
          last_pos_q   <= calc_last_pos;
          cur_word_q   <= calc_first_word;
          ovf_q        <= calc_ovf;
          state_q      <= calc_empty ? ST_FINISH : ST_WAKE;
        end
        ST_WAKE:   if (tick) state_q <= ST_STROBE;
        ST_STROBE: if (tick) state_q <= ST_DRAIN;
        ST_DRAIN:  if (!em_active) state_q <= ST_HOLD;
        ST_HOLD: if (tick) begin
          if (cur_word_q == last_word_q) begin
            state_q <= ST_FINISH;
          end else begin
            cur_word_q <= cur_word_q + WORD_W'(1);
            state_q    <= ST_STROBE;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WAKE, ST_DRAIN, ST_HOLD: fuse_ctl = CTL_LOADCFG;
      ST_STROBE:                  fuse_ctl = CTL_LOADCFG | CTL_STROBE_ON;
      default:                    fuse_ctl = CTL_STANDBY;
    endcase
  end

  assign fuse_addr = ADDR_W'(cur_word_q);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FINISH);
  assign overflow  = done && ovf_q;
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [9:0]        fuse_ctl,
  input logic [ADDR_W-1:0] fuse_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              busy,
  input logic              done,
  input logic              overflow
);
  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fuse_ctl == 10'h021) && !out_valid);

  p_strobe_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctl[1] |-> fuse_ctl[2] && fuse_ctl[3] && !fuse_ctl[5] && !fuse_ctl[0]);

  p_strobe_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctl[1] |=> !fuse_ctl[1] || $stable(fuse_addr));

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_bp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done);

  p_stream_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fuse_ctl == 10'h021) && !out_valid);
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fuse_ctl(fuse_ctl), .fuse_addr(fuse_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .busy(busy), .done(done), .overflow(overflow)
);

// File: tb/fuse_rd_seq_bench.sv
module fuse_rd_seq_bench;
  localparam int TICKS = 3;
  localparam int VEC_N = 9;
  localparam int VEC_OFF [VEC_N] = '{0, 1, 3, 64, 7, 126, 125, 0, 120};
  localparam int VEC_LEN [VEC_N] = '{4, 2, 6, 1, 9, 2, 10, 128, 8};
  localparam int VEC_NB  [VEC_N] = '{4, 2, 6, 1, 9, 2, 3, 128, 8};
  localparam int VEC_OVF [VEC_N] = '{0, 0, 0, 0, 0, 0, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [7:0]  req_length = '0;
  logic [9:0]  fuse_ctl;
  logic [9:0]  fuse_addr;
  logic [31:0] fuse_dout;
  logic        out_valid, out_last, busy, done, overflow;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fuse_rd_seq #(.TICKS_PER_US(TICKS)) u_fuse_rd_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_offset(req_offset), .req_length(req_length),
    .fuse_ctl(fuse_ctl), .fuse_addr(fuse_addr), .fuse_dout(fuse_dout),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .busy(busy), .done(done), .overflow(overflow)
  );

  function automatic logic [7:0] rom_byte(input int i);
    return 8'((i * 37 + 11) ^ (i / 8));
  endfunction

  // fuse macro model: data only meaningful while strobe is high
  int rom_base;
  always_comb begin
    rom_base  = 4 * int'(fuse_addr);
    fuse_dout = fuse_ctl[1] ? {rom_byte(rom_base + 3), rom_byte(rom_base + 2),
                               rom_byte(rom_base + 1), rom_byte(rom_base)}
                            : 32'hDEAD_BEEF;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: sampled on falling edges
  logic [7:0] rx [0:255];
  int addr_log [0:63];
  int rx_cnt, last_cnt, last_idx, req_strobes, load_run, hi_run, low_run;
  int wid_bad, gap_bad, total_done, total_strobes;
  bit prev_s, prev_busy, after_strobe, ovf_seen;
  logic [7:0] lfsr = 8'hA1;

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = lfsr[0] | lfsr[3];
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rx_cnt = 0; last_cnt = 0; last_idx = -1; req_strobes = 0; load_run = 0;
        hi_run = 0; low_run = 0; wid_bad = 0; gap_bad = 0; after_strobe = 0; ovf_seen = 0;
      end
      if (out_valid && out_ready) begin
        if (rx_cnt < 256) rx[rx_cnt] = out_data;
        if (out_last) begin last_cnt++; last_idx = rx_cnt; end
        rx_cnt++;
      end
      if (fuse_ctl == 10'h28C && req_strobes == 0) load_run++;
      if (fuse_ctl[1]) begin
        if (!prev_s) begin
          if (req_strobes < 64) addr_log[req_strobes] = int'(fuse_addr);
          req_strobes++;
          total_strobes++;
          if (after_strobe && low_run < TICKS) gap_bad++;
        end
        hi_run++;
      end else begin
        if (prev_s) begin
          if (hi_run != TICKS) wid_bad++;
          hi_run = 0; low_run = 0; after_strobe = 1;
        end
        if (after_strobe) low_run++;
      end
      if (done) begin
        total_done++;
        ovf_seen = overflow;
        if (after_strobe && low_run < TICKS) gap_bad++;
        after_strobe = 0;
      end
      prev_s = fuse_ctl[1];
      prev_busy = busy;
    end
  end

  task automatic run_req(input int off, input int len, input int exp_nb,
                         input int exp_ovf, input bit poke);
    int td0, ts0, t, bad, fw, nw;
    bit empty, done_first;
    empty = (len == 0) || (off >= 128);
    fw = off / 4;
    nw = (exp_nb == 0) ? 0 : ((off + exp_nb - 1) / 4 - fw + 1);
    td0 = total_done;
    @(negedge clk);
    req_offset = 8'(off); req_length = 8'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_first = done;
    check(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
    t = 0;
    while (total_done == td0 && t < 5000) begin
      @(negedge clk);
      t++;
      if (poke && t == 4) begin
        req_offset = 8'd100; req_length = 8'd20; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(t < 5000, "R11", "request completes", t, 0);
    ts0 = total_strobes;
    repeat (poke ? 40 : 2) @(negedge clk);
    check(total_done - td0 == 1, "R11", "done pulses", total_done - td0, 1);
    if (poke) check(total_strobes == ts0, "R10", "strobes after ignored start", total_strobes - ts0, 0);
    check(fuse_ctl == 10'h021 && !busy, "R11", "standby after done", int'(fuse_ctl), 'h021);
    if (empty) check(done_first == 1'b1, "R8", "done right after start", int'(done_first), 1);
    check(rx_cnt == exp_nb, "R5", "byte count", rx_cnt, exp_nb);
    bad = 0;
    for (int i = 0; i < exp_nb && i < rx_cnt; i++)
      if (rx[i] != rom_byte(off + i)) bad++;
    check(bad == 0, "R5", "byte values", bad, 0);
    if (exp_nb > 0) begin
      check(last_cnt == 1, "R6", "last flag count", last_cnt, 1);
      check(last_idx == exp_nb - 1, "R6", "last flag position", last_idx, exp_nb - 1);
    end else begin
      check(last_cnt == 0, "R6", "no last flag", last_cnt, 0);
    end
    check(req_strobes == nw, "R4", "words strobed", req_strobes, nw);
    bad = 0;
    for (int k = 0; k < nw && k < 64; k++)
      if (addr_log[k] != fw + k) bad++;
    check(bad == 0, "R4", "word addresses", bad, 0);
    check(wid_bad == 0, "R3", "strobe width", wid_bad, 0);
    check(gap_bad == 0, "R3", "strobe low gap", gap_bad, 0);
    check(load_run == (empty ? 0 : TICKS), "R2", "load phase cycles", load_run, empty ? 0 : TICKS);
    check(int'(ovf_seen) == exp_ovf, "R9", "overflow with done", int'(ovf_seen), exp_ovf);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(fuse_ctl == 10'h021, "R1", "ctl in reset", int'(fuse_ctl), 'h021);
    rst_n = 1'b1;
    @(negedge clk);
    check(fuse_ctl == 10'h021, "R1", "ctl after reset", int'(fuse_ctl), 'h021);
    check(!busy && !out_valid && !done, "R1", "idle outputs",
          int'({busy, out_valid, done}), 0);

    for (int v = 0; v < VEC_N; v++)
      run_req(VEC_OFF[v], VEC_LEN[v], VEC_NB[v], VEC_OVF[v], 1'b0);

    // R8: empty requests, zero length and out-of-range offset
    run_req(5, 0, 0, 0, 1'b0);
    run_req(130, 4, 0, 1, 1'b0);
    run_req(128, 0, 0, 0, 1'b0);
    // R9: single byte at the very end, and a long run past the end
    run_req(127, 1, 1, 0, 1'b0);
    run_req(100, 200, 28, 1, 1'b0);
    // R10: start pulse during a request is ignored
    run_req(8, 4, 4, 0, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule